// File: doc/BRIEF.md
# Nibble-Serial Register Access Port

This block lets a host reach a bank of 8-bit registers through a stream of command bytes. The upper nibble of each byte selects an operation and the lower nibble carries four bits of payload. The host builds an 8-bit register address from two nibble commands. It stages a data byte the same way, and the data byte is written on the command that carries its upper nibble. A read command hands the addressed register's byte back on a response stream, and it can optionally step the address so that wide counters can be read one byte after another.

The register bank itself lives outside the block. The block drives an address, write data, a write strobe and a read strobe, and it samples the bank's read data in the same cycle. Read responses wait in a small queue. The command input stops accepting bytes whenever that queue is full.

Top module: `nsr_port`

## Requirements
- R1: A synchronous active-high reset sets the address to 0x00 and the staged low data nibble to 0x0, empties the response queue (`rsp_valid` low) and leaves `cmd_ready` high.
- R2: Command bytes 0x0N and 0x1N load N into bits 3:0 and bits 7:4 of the address respectively, leaving the other half of the address unchanged.
- R3: Command byte 0x2N stages N as the low data nibble and writes nothing. Command byte 0x3N raises `reg_we` for exactly its acceptance cycle, with `reg_wdata` = {N, staged low nibble} and `reg_addr` = current address.
- R4: Writes never change the address. Several low/high data pairs after one address therefore write successive bytes to that same register, in the order they are sent.
- R5: The staged low nibble stays in place after a write and across address changes. A 0x3N command with no new 0x2N before it writes {N, most recent low nibble}.
- R6: Command byte 0x4X (payload X ignored) raises `reg_re` in its acceptance cycle, leaves the address unchanged, and queues the register byte. That byte is presented on `rsp_data` with `rsp_valid` high from the next cycle on.
- R7: Command byte 0x5X reads like 0x4X and then increments the address by one, wrapping from 0xFF to 0x00. Six such reads return six consecutive registers, lowest address first.
- R8: Responses leave in the order they were requested, and none is lost. While the queue holds RESP_DEPTH bytes, `cmd_ready` is low and no command is accepted.
- R9: Command bytes with an upper nibble of 0x6 to 0xF have no effect: no write, no read, no response and no change of address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_data | input | 8 | Command byte: operation in bits 7:4, payload in bits 3:0 |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Command byte can be accepted (response queue not full) |
| rsp_data | output | 8 | Oldest queued read response |
| rsp_valid | output | 1 | A response is queued |
| rsp_ready | input | 1 | Host takes the response this cycle |
| reg_addr | output | 8 | Register bank address |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe |
| reg_re | output | 1 | Register bank read strobe |
| reg_rdata | input | 8 | Register bank read data, sampled while reg_re is high |

## Verification
Writes and read strobes are combinational on the accepting cycle: they land in the register bank at the edge that accepts the command. Address and nibble updates are visible on `reg_addr` one edge later, and a read response appears on `rsp_valid`/`rsp_data` one edge after its command is accepted. The bench drives every input at the falling edge. It reads the results at the falling edge that follows the accepting rising edge, which is the first point where each of these results is due. For the stall case it holds a command for several cycles, checks that no read strobe occurred, and then counts the drained responses in order.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

   typedef enum logic [3:0] {
      OP_ADDR_LO  = 4'h0,
      OP_ADDR_HI  = 4'h1,
      OP_DATA_LO  = 4'h2,
      OP_DATA_HI  = 4'h3,
      OP_READ     = 4'h4,
      OP_READ_INC = 4'h5
   } nsr_op_e;

   typedef struct packed {
      logic set_alo;
      logic set_ahi;
      logic set_dlo;
      logic wr;
      logic rd;
      logic inc;
   } nsr_cmd_t;

endpackage

// File: rtl/nsr_decode.sv
module nsr_decode
   import nsr_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic [2*NIB_W-1:0] cmd,
   input  logic               fire,
   output nsr_cmd_t           dec,
   output logic [NIB_W-1:0]   nib
);

   assign nib = cmd[NIB_W-1:0];

   always_comb begin
      dec = '0;
      if (fire) begin
         case (cmd[2*NIB_W-1:NIB_W])
            OP_ADDR_LO:  dec.set_alo = 1'b1;
            OP_ADDR_HI:  dec.set_ahi = 1'b1;
            OP_DATA_LO:  dec.set_dlo = 1'b1;
            OP_DATA_HI:  dec.wr      = 1'b1;
            OP_READ:     dec.rd      = 1'b1;
            OP_READ_INC: begin
               dec.rd  = 1'b1;
               dec.inc = 1'b1;
            end
            default:     dec = '0;
         endcase
      end
   end

endmodule

// File: rtl/nsr_ctx.sv
module nsr_ctx
   import nsr_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  nsr_cmd_t           dec,
   input  logic               inc_en,
   input  logic [NIB_W-1:0]   nib,
   output logic [2*NIB_W-1:0] addr,
   output logic [NIB_W-1:0]   dlo
);

   always_ff @(posedge clk) begin
      if (rst) begin
         addr <= '0;
         dlo  <= '0;
      end else begin
         if (dec.set_alo) addr[NIB_W-1:0] <= nib;
         if (dec.set_ahi) addr[2*NIB_W-1:NIB_W] <= nib;
         if (dec.inc && inc_en) addr <= addr + 1'b1;
         if (dec.set_dlo) dlo <= nib;
      end
   end

endmodule

// File: rtl/nsr_fifo.sv
module nsr_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nsr_fifo: DEPTH must be a power of two of at least 2");
   end

   logic [PW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic [W-1:0]  slot_q [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (push && wptr == PW'(e)) q <= wdata;
      end
      assign slot_q[e] = q;
   end

   assign rdata = slot_q[rptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/nsr_port.sv
module nsr_port
   import nsr_pkg::*;
#(
   parameter int RESP_DEPTH  = 4,
   parameter bit ADDR_INC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [7:0] cmd_data,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   output logic [7:0] rsp_data,
   output logic       rsp_valid,
   input  logic       rsp_ready,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   output logic       reg_we,
   output logic       reg_re,
   input  logic [7:0] reg_rdata
);

   localparam int NIB_W  = 4;
   localparam int BYTE_W = 2 * NIB_W;

   nsr_cmd_t         dec;
   logic [NIB_W-1:0] nib, dlo;
   logic [BYTE_W-1:0] addr;
   logic             fire, full, empty, inc_en;

   assign fire = cmd_valid && cmd_ready;

   if (ADDR_INC_EN) begin : g_inc_on
      assign inc_en = 1'b1;
   end else begin : g_inc_off
      assign inc_en = 1'b0;
   end

   nsr_decode #(.NIB_W(NIB_W)) u_dec (
      .cmd  (cmd_data),
      .fire (fire),
      .dec  (dec),
      .nib  (nib)
   );

   nsr_ctx #(.NIB_W(NIB_W)) u_ctx (
      .clk    (clk),
      .rst    (rst),
      .dec    (dec),
      .inc_en (inc_en),
      .nib    (nib),
      .addr   (addr),
      .dlo    (dlo)
   );

   nsr_fifo #(.W(BYTE_W), .DEPTH(RESP_DEPTH)) u_rsp (
      .clk   (clk),
      .rst   (rst),
      .push  (dec.rd),
      .wdata (reg_rdata),
      .pop   (rsp_valid && rsp_ready),
      .rdata (rsp_data),
      .full  (full),
      .empty (empty)
   );

   assign cmd_ready = !full;
   assign rsp_valid = !empty;
   assign reg_addr  = addr;
   assign reg_wdata = {nib, dlo};
   assign reg_we    = dec.wr;
   assign reg_re    = dec.rd;

endmodule

// File: rtl/nsr_port_chk.sv
module nsr_port_chk #(
   parameter int RESP_DEPTH  = 4,
   parameter bit ADDR_INC_EN = 1'b1
) (
   input logic       clk,
   input logic       rst,
   input logic [7:0] cmd_data,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [7:0] rsp_data,
   input logic       rsp_valid,
   input logic       rsp_ready,
   input logic [7:0] reg_addr,
   input logic       reg_we,
   input logic       reg_re
);

   localparam int PCW = $clog2(RESP_DEPTH + 1) + 1;

   logic [PCW-1:0] pending;
   logic           acc;
   logic           pop;

   assign acc = cmd_valid && cmd_ready;
   assign pop = rsp_valid && rsp_ready;

   always_ff @(posedge clk) begin
      if (rst) pending <= '0;
      else pending <= pending + PCW'(reg_re) - PCW'(pop);
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!rsp_valid && reg_addr == 8'h00));

   assert_addr_lo_R2: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_data[7:4] == 4'h0) |=>
      (reg_addr[3:0] == $past(cmd_data[3:0]) && reg_addr[7:4] == $past(reg_addr[7:4])));

   assert_we_source_R3: assert property (@(posedge clk) disable iff (rst)
      reg_we |-> (acc && cmd_data[7:4] == 4'h3));

   assert_write_keeps_addr_R4: assert property (@(posedge clk) disable iff (rst)
      reg_we |=> $stable(reg_addr));

   assert_resp_due_R6: assert property (@(posedge clk) disable iff (rst)
      rsp_valid == (pending != '0));

   assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
      (ADDR_INC_EN && acc && cmd_data[7:4] == 4'h5) |=> reg_addr == $past(reg_addr) + 8'h01);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
      pending <= PCW'(RESP_DEPTH));

   assert_stall_full_R8: assert property (@(posedge clk) disable iff (rst)
      (pending == PCW'(RESP_DEPTH)) |-> !cmd_ready);

   assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

   assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_data[7:4] >= 4'h6) |-> (!reg_we && !reg_re));

   assert_ignore_addr_R9: assert property (@(posedge clk) disable iff (rst)
      (acc && cmd_data[7:4] >= 4'h6) |=> $stable(reg_addr));

endmodule

bind nsr_port nsr_port_chk #(
   .RESP_DEPTH  (RESP_DEPTH),
   .ADDR_INC_EN (ADDR_INC_EN)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_data  (cmd_data),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .rsp_data  (rsp_data),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_re    (reg_re)
);

// File: tb/tb_nsr_port.sv
module tb_nsr_port;

   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] cmd_data = 8'h00;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [7:0] rsp_data;
   logic       rsp_valid;
   logic       rsp_ready = 1'b1;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic       reg_we, reg_re;

   always #2 clk = ~clk;

   nsr_port #(.RESP_DEPTH(DEPTH), .ADDR_INC_EN(1'b1)) dut (
      .clk       (clk),
      .rst       (rst),
      .cmd_data  (cmd_data),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .rsp_data  (rsp_data),
      .rsp_valid (rsp_valid),
      .rsp_ready (rsp_ready),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   // register bank model and stream monitors
   logic [7:0] mem [256];
   logic [7:0] rx [$];
   int         wr_cnt = 0;
   int         rd_cnt = 0;
   logic [7:0] wlog_a [8];
   logic [7:0] wlog_d [8];

   assign reg_rdata = mem[reg_addr];

   always @(posedge clk) begin
      if (reg_we) begin
         mem[reg_addr] <= reg_wdata;
         wlog_a[wr_cnt % 8] = reg_addr;
         wlog_d[wr_cnt % 8] = reg_wdata;
         wr_cnt = wr_cnt + 1;
      end
      if (reg_re) rd_cnt = rd_cnt + 1;
      if (rsp_valid && rsp_ready) rx.push_back(rsp_data);
   end

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   function automatic logic [7:0] init_val(int a);
      return 8'(a * 7 + 3);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(logic [7:0] b);
      cmd_data  = b;
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_addr(logic [7:0] a);
      send({4'h0, a[3:0]});
      send({4'h1, a[7:4]});
   endtask

   task automatic write_byte(logic [7:0] d);
      send({4'h2, d[3:0]});
      send({4'h3, d[7:4]});
   endtask

   task automatic expect_rx(string req, logic [7:0] exp);
      for (int i = 0; i < 10 && rx.size() == 0; i++) @(negedge clk);
      if (rx.size() == 0) chk(req, -1, exp);
      else chk(req, rx.pop_front(), exp);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 rsp_valid after reset", rsp_valid, 0);
      chk("R1 cmd_ready after reset", cmd_ready, 1);
      chk("R1 address after reset", reg_addr, 8'h00);
      send(8'h35);
      chk("R1/R5 high-only write uses cleared low nibble", mem[0], 8'h50);
      send(8'h40);
      expect_rx("R1/R6 read at reset address", 8'h50);
   endtask

   task automatic t_addr();
      set_addr(8'h3C);
      chk("R2 address from two nibbles", reg_addr, 8'h3C);
      send(8'h40);
      expect_rx("R2 read assembled address", init_val(8'h3C));
      send(8'h07);
      chk("R2 low nibble only replaces bits 3:0", reg_addr, 8'h37);
      send(8'h1A);
      chk("R2 high nibble only replaces bits 7:4", reg_addr, 8'hA7);
   endtask

   task automatic t_write();
      int w0;
      set_addr(8'h12);
      w0 = wr_cnt;
      send(8'h27);
      chk("R3 low data nibble writes nothing", wr_cnt, w0);
      send(8'h3A);
      chk("R3 high data nibble writes once", wr_cnt, w0 + 1);
      chk("R3 written byte", mem[8'h12], 8'hA7);
   endtask

   task automatic t_multi();
      int w0;
      set_addr(8'h20);
      w0 = wr_cnt;
      write_byte(8'h11);
      write_byte(8'h22);
      write_byte(8'h33);
      chk("R4 three writes", wr_cnt, w0 + 3);
      for (int i = 0; i < 3; i++) begin
         chk("R4 write address held", wlog_a[(w0 + i) % 8], 8'h20);
         chk("R4 write order", wlog_d[(w0 + i) % 8], 8'h11 * (i + 1));
      end
      chk("R4 address after writes", reg_addr, 8'h20);
   endtask

   task automatic t_stale();
      set_addr(8'h40);
      write_byte(8'h5A);
      send(8'h36);
      chk("R5 stale low nibble reused", mem[8'h40], 8'h6A);
      set_addr(8'h41);
      send(8'h39);
      chk("R5 stale low nibble across address change", mem[8'h41], 8'h9A);
   endtask

   task automatic t_read();
      set_addr(8'h55);
      rsp_ready = 1'b0;
      send(8'h4F);
      chk("R6 response valid one cycle after read", rsp_valid, 1);
      chk("R6 response byte", rsp_data, init_val(8'h55));
      chk("R6 plain read keeps address", reg_addr, 8'h55);
      rsp_ready = 1'b1;
      expect_rx("R6 response delivered", init_val(8'h55));
   endtask

   task automatic t_burst();
      set_addr(8'h80);
      for (int i = 0; i < 6; i++) send(8'h50);
      for (int i = 0; i < 6; i++) expect_rx("R7 burst byte", init_val(8'h80 + i));
      chk("R7 address after burst", reg_addr, 8'h86);
      set_addr(8'hFF);
      send(8'h50);
      chk("R7 address wraps to zero", reg_addr, 8'h00);
      send(8'h40);
      expect_rx("R7 byte before wrap", init_val(8'hFF));
      expect_rx("R7 byte after wrap", 8'h50);
   endtask

   task automatic t_full();
      int r0;
      set_addr(8'h90);
      rsp_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) send(8'h50);
      chk("R8 input stalls when queue full", cmd_ready, 0);
      r0 = rd_cnt;
      cmd_data  = 8'h50;
      cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 no read while stalled", rd_cnt, r0);
      chk("R8 address held while stalled", reg_addr, 8'h90 + DEPTH);
      rsp_ready = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (8) @(negedge clk);
      chk("R8 response count", rx.size(), DEPTH + 1);
      for (int i = 0; i <= DEPTH; i++) expect_rx("R8 response order", init_val(8'h90 + i));
   endtask

   task automatic t_ignore();
      int w0, r0;
      set_addr(8'h44);
      w0 = wr_cnt;
      r0 = rd_cnt;
      send(8'h6F);
      send(8'h9A);
      send(8'hF3);
      send(8'h7C);
      repeat (3) @(negedge clk);
      chk("R9 no write from unused codes", wr_cnt, w0);
      chk("R9 no read from unused codes", rd_cnt, r0);
      chk("R9 no response from unused codes", rx.size(), 0);
      chk("R9 address unchanged", reg_addr, 8'h44);
      send(8'h40);
      expect_rx("R9 register untouched", init_val(8'h44));
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
      @(negedge clk);
      t_reset();
      t_addr();
      t_write();
      t_multi();
      t_stale();
      t_read();
      t_burst();
      t_full();
      t_ignore();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule